// File: doc/BRIEF.md
# Burst DRAM Access Sequencer

This block turns one request from a simple requester into the command, address and data traffic of a DRAM-style bus. Each request moves four 64-bit words. The start address is split into a row part and a column part. The block drives an activate command with the row and fills the following cycles with no-operation commands. It then drives a read or write command with the column and moves the data words in fixed beat cycles.

Two timing styles are offered, and the choice is made when the request is accepted. In burst style, the first word arrives after the full initial latency and the other three words follow on the next three cycles (6-1-1-1 with default parameters). In legacy style, every word repeats the whole activate, column and data sequence (6-6-6-6, which is 24 cycles). Legacy style addresses each word with its own column. That column wraps inside the aligned group of four.

Top module: `dram_burst_seq`

## Requirements
- R1: Every accepted request produces exactly four data beats, counted on `rdata_valid` for reads and on `wdata_take` for writes, before its `done` pulse.
- R2: Command encodings on `mem_cmd` are NOP=3'b000, ACT=3'b001, RD=3'b010 and WR=3'b011. While ACT is driven, `mem_addr` carries `addr[ADDR_W-1:COL_W]` (the row), zero-extended. While the first RD/WR is driven, `mem_addr` carries `addr[COL_W-1:0]` (the column), zero-extended. When no command is driven, `mem_addr` is zero.
- R3: Within one word sequence, ACT is followed by NOP_GAP NOP cycles and then by RD (read) or WR (write). Every other busy cycle carries NOP.
- R4: The first data beat falls CAS_LATENCY cycles after the RD/WR command, which is the sixth cycle counting the ACT cycle as the first. During a read beat, `rdata` equals `mem_rdata` of that cycle.
- R5: With `burst_mode`=1, the second, third and fourth beats fall on the three cycles directly after the first beat. Only NOP is driven during the beats, and there is a single ACT and a single RD/WR per request.
- R6: With `burst_mode`=0, each of the four words gets its own ACT (same row), NOP gap, RD/WR and beat, with the next ACT on the cycle after the beat. Word k (0..3) uses the start column with bits [1:0] replaced by (start[1:0]+k) mod 4 and with the upper bits unchanged.
- R7: For writes, WR replaces RD. In each beat cycle `wdata_take` and `mem_wdata_en` are 1 and `mem_wdata` equals `wdata`. `rdata_valid` and `wdata_take` are never both 1.
- R8: `ack` is 1 exactly when `req` is 1 while the block is idle. ACT appears in the cycle after `ack`. `busy` stays 1 from that cycle through the last beat, and a request made while busy gets no `ack`.
- R9: `done` is a single-cycle pulse in the cycle after the fourth beat, with `busy` already 0. A request held in that cycle is accepted there.
- R10: Direction, timing style and address are captured at acceptance. Changes on `we`, `burst_mode` or `addr` during an access do not alter that access.
- R11: A synchronous active-high `rst` makes the block idle from the next cycle, with NOP on `mem_cmd`, and with `busy`, `done`, `rdata_valid` and `wdata_take` at 0, even when it arrives in the middle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| burst_mode | input | 1 | 1 = burst timing, 0 = legacy per-word timing |
| addr | input | ADDR_W | Start word address, row above column |
| wdata | input | DATA_W | Write word supplied during write beats |
| ack | output | 1 | Request accepted this cycle |
| busy | output | 1 | Access in progress |
| wdata_take | output | 1 | Write word is consumed this cycle |
| rdata | output | DATA_W | Read word |
| rdata_valid | output | 1 | Read word valid this cycle |
| done | output | 1 | Access finished |
| mem_cmd | output | 3 | Bus command |
| mem_addr | output | CA_W | Row or column address on the bus |
| mem_wdata | output | DATA_W | Write data to the bus |
| mem_wdata_en | output | 1 | Bus write data valid |
| mem_rdata | input | DATA_W | Read data from the bus |

## Verification
The `done` pulse of one access and the acceptance of the next request can fall in the same cycle. This case is provoked by holding `req` high through a whole access while `we`, `burst_mode` and `addr` are changed in mid-flight. The reference model marks the done cycle as not busy, so it expects `ack` there. It then expects the new access's ACT on the very next cycle, built from the input values present at that acceptance and not from the earlier ones.

// File: rtl/dram_burst_seq.sv
module dram_burst_seq #(
  parameter int ROW_W = 12,
  parameter int COL_W = 10,
  parameter int DATA_W = 64,
  parameter int NOP_GAP = 2,
  parameter int CAS_LATENCY = 2,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int CA_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic              burst_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic              busy,
  output logic              wdata_take,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid,
  output logic              done,
  output logic [2:0]        mem_cmd,
  output logic [CA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wdata_en,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int RD_POS   = NOP_GAP + 1;
  localparam int DATA_POS = RD_POS + CAS_LATENCY;
  localparam int POS_W    = $clog2(DATA_POS + 1);
  localparam logic [2:0] C_NOP = 3'b000;
  localparam logic [2:0] C_ACT = 3'b001;
  localparam logic [2:0] C_RD  = 3'b010;
  localparam logic [2:0] C_WR  = 3'b011;

  logic             busy_q, we_q, burst_q, done_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [POS_W-1:0] pos_q;
  logic [1:0]       beat_q;
  logic             beat, last, at_act, at_col;
  logic [COL_W-1:0] col_now;

  assign beat    = busy_q && (pos_q == POS_W'(DATA_POS));
  assign last    = beat && (beat_q == 2'd3);
  assign at_act  = busy_q && (pos_q == '0);
  assign at_col  = busy_q && (pos_q == POS_W'(RD_POS));
  assign col_now = {col_q[COL_W-1:2], col_q[1:0] + beat_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      burst_q <= 1'b0;
      done_q  <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      pos_q   <= '0;
      beat_q  <= '0;
    end else begin
      done_q <= last;
      if (!busy_q) begin
        if (req) begin
          busy_q  <= 1'b1;
          we_q    <= we;
          burst_q <= burst_mode;
          row_q   <= addr[ADDR_W-1:COL_W];
          col_q   <= addr[COL_W-1:0];
          pos_q   <= '0;
          beat_q  <= '0;
        end
      end else if (beat) begin
        beat_q <= beat_q + 2'd1;
        if (!burst_q) pos_q <= '0;
        if (last) busy_q <= 1'b0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign ack  = req && !busy_q;
  assign busy = busy_q;
  assign done = done_q;

  assign mem_cmd  = at_act ? C_ACT : at_col ? (we_q ? C_WR : C_RD) : C_NOP;
  assign mem_addr = at_act ? CA_W'(row_q) : at_col ? CA_W'(col_now) : '0;

  assign rdata_valid  = beat && !we_q;
  assign rdata        = mem_rdata;
  assign wdata_take   = beat && we_q;
  assign mem_wdata_en = wdata_take;
  assign mem_wdata    = wdata_take ? wdata : '0;
endmodule

// File: rtl/dram_burst_seq_chk.sv
module dram_burst_seq_chk #(
  parameter int NOP_GAP = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       ack,
  input logic       busy,
  input logic       done,
  input logic       burst_mode,
  input logic       rdata_valid,
  input logic       wdata_take,
  input logic [2:0] mem_cmd
);
  localparam int SA_W = $clog2(NOP_GAP + 3) + 1;
  localparam logic [SA_W-1:0] SA_CAP = SA_W'(NOP_GAP + 2);

  logic            burst_l;
  logic [2:0]      nb;
  logic [SA_W-1:0] sa;
  logic            strobe;

  assign strobe = rdata_valid || wdata_take;

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_l <= 1'b0;
      nb      <= '0;
      sa      <= '0;
    end else begin
      if (ack) begin
        burst_l <= burst_mode;
        nb      <= '0;
      end else if (strobe) begin
        nb <= nb + 3'd1;
      end
      if (mem_cmd == 3'b001) sa <= SA_W'(1);
      else if (sa != '0 && sa < SA_CAP) sa <= sa + 1'b1;
    end
  end

  AST_ACK_THEN_ACT: assert property (@(posedge clk) disable iff (rst) ack |=> (busy && mem_cmd == 3'b001)); // R8
  AST_COL_SPACING: assert property (@(posedge clk) disable iff (rst) (mem_cmd == 3'b010 || mem_cmd == 3'b011) |-> (sa == SA_W'(NOP_GAP + 1))); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst) !(rdata_valid && wdata_take)); // R7
  AST_FOUR_BEATS: assert property (@(posedge clk) disable iff (rst) done |-> (nb == 3'd4)); // R1
  AST_BURST_TRAIN: assert property (@(posedge clk) disable iff (rst) (burst_l && strobe && nb < 3'd3) |=> strobe); // R5
  AST_BEAT_QUIET: assert property (@(posedge clk) disable iff (rst) strobe |-> (mem_cmd == 3'b000)); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(strobe))); // R9
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!busy && mem_cmd == 3'b000 && !strobe && !done)); // R11
endmodule

bind dram_burst_seq dram_burst_seq_chk #(.NOP_GAP(NOP_GAP)) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .busy(busy), .done(done),
  .burst_mode(burst_mode), .rdata_valid(rdata_valid), .wdata_take(wdata_take),
  .mem_cmd(mem_cmd)
);

// File: tb/dram_burst_seq_bench.sv
module dram_burst_seq_bench;
  localparam int ROW_W = 12, COL_W = 10, DW = 64;

  logic clk = 1'b0, rst = 1'b1, req = 1'b0, we = 1'b0, burst_mode = 1'b0;
  logic [ROW_W+COL_W-1:0] addr = '0;
  logic [DW-1:0] wdata, rdata, mem_wdata, mem_rdata;
  logic ack, busy, wdata_take, rdata_valid, done, mem_wdata_en;
  logic [2:0] mem_cmd;
  logic [11:0] mem_addr;
  int checks = 0, fails = 0, cyc = 0, nbeats = 0;
  bit rst_d = 1'b1;

  always #2 clk = ~clk;

  assign mem_rdata = {32'hC0DE_0000 ^ 32'(cyc), 32'(cyc) * 7};
  assign wdata     = {32'(cyc) * 3, 32'h5A5A_0000 ^ 32'(cyc)};

  dram_burst_seq u_dram_burst_seq (
    .clk(clk), .rst(rst), .req(req), .we(we), .burst_mode(burst_mode), .addr(addr),
    .wdata(wdata), .ack(ack), .busy(busy), .wdata_take(wdata_take), .rdata(rdata),
    .rdata_valid(rdata_valid), .done(done), .mem_cmd(mem_cmd), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wdata_en(mem_wdata_en), .mem_rdata(mem_rdata)
  );

  typedef struct {
    logic [2:0]  cmd;
    logic [11:0] a;
    bit rv, wt, dn, bz, burst;
  } ent_t;
  ent_t q[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  function automatic ent_t mk(logic [2:0] c, logic [11:0] a, bit rv, bit wt, bit dn, bit bz, bit b);
    ent_t e;
    e.cmd = c; e.a = a; e.rv = rv; e.wt = wt; e.dn = dn; e.bz = bz; e.burst = b;
    return e;
  endfunction

  function automatic void push_sched(bit w, bit b, logic [21:0] a);
    logic [2:0] cc = w ? 3'b011 : 3'b010;
    logic [11:0] row = a[21:10];
    int words = b ? 1 : 4;
    for (int k = 0; k < words; k++) begin
      logic [9:0] ck = {a[9:2], a[1:0] + 2'(k)};
      q.push_back(mk(3'b001, row, 0, 0, 0, 1, b));
      q.push_back(mk(3'b000, '0, 0, 0, 0, 1, b));
      q.push_back(mk(3'b000, '0, 0, 0, 0, 1, b));
      q.push_back(mk(cc, {2'b00, ck}, 0, 0, 0, 1, b));
      q.push_back(mk(3'b000, '0, 0, 0, 0, 1, b));
      q.push_back(mk(3'b000, '0, !w, w, 0, 1, b));
    end
    if (b) for (int k = 0; k < 3; k++) q.push_back(mk(3'b000, '0, !w, w, 0, 1, b));
    q.push_back(mk(3'b000, '0, 0, 0, 1, 0, b));
  endfunction

  always @(negedge clk) begin
    ent_t e;
    if (rst) begin
      q.delete();
      nbeats = 0;
    end else begin
      e = (q.size() > 0) ? q[0] : mk(3'b000, '0, 0, 0, 0, 0, 0);
      if (rst_d) chk(!busy && mem_cmd == 3'b000 && !rdata_valid && !wdata_take && !done,
                     "R11", {busy, mem_cmd, rdata_valid, wdata_take, done}, 64'h0);
      chk(mem_cmd === e.cmd, "R3", 64'(mem_cmd), 64'(e.cmd));
      chk(mem_addr === e.a, (e.burst || e.cmd == 3'b001) ? "R2" : "R6", 64'(mem_addr), 64'(e.a));
      chk(rdata_valid === e.rv, e.burst ? "R5" : "R6", 64'(rdata_valid), 64'(e.rv));
      chk(wdata_take === e.wt && mem_wdata_en === e.wt, "R7", {wdata_take, mem_wdata_en}, {2{e.wt}});
      chk(done === e.dn, "R9", 64'(done), 64'(e.dn));
      chk(busy === (e.bz && !e.dn), "R8", 64'(busy), 64'(e.bz));
      chk(ack === (req && !e.bz), "R8", 64'(ack), 64'(req && !e.bz));
      if (e.rv) chk(rdata === mem_rdata, "R4", rdata, mem_rdata);
      if (e.wt) chk(mem_wdata === wdata, "R7", mem_wdata, wdata);
      if (rdata_valid || wdata_take) nbeats++;
      if (done) begin
        chk(nbeats == 4, "R1", 64'(nbeats), 64'd4);
        nbeats = 0;
      end
      if (q.size() > 0) void'(q.pop_front());
      if (req && !e.bz) push_sched(we, burst_mode, addr);
    end
    rst_d = rst;
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog cycle %0d: actual hung expected finish", cyc);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  task automatic go(input bit w, input bit b, input logic [21:0] a);
    @(posedge clk); #1;
    req = 1'b1; we = w; burst_mode = b; addr = a;
    do @(negedge clk); while (!ack);
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    go(0, 1, {12'h0A5, 10'h001}); wait_done();     // R5 burst read
    go(0, 0, {12'h3C3, 10'h2FE}); wait_done();     // R6 legacy read, column wrap
    go(1, 1, {12'h111, 10'h0C3}); wait_done();     // R7 burst write
    go(1, 0, {12'h0F0, 10'h3FF}); wait_done();     // R7 legacy write
    // R8 R9 R10: req held high, inputs changed mid-access, next accepted in done cycle
    @(posedge clk); #1;
    req = 1'b1; we = 1'b0; burst_mode = 1'b1; addr = {12'h222, 10'h00A};
    do @(negedge clk); while (!ack);
    @(posedge clk); #1;
    we = 1'b1; burst_mode = 1'b0; addr = {12'hABC, 10'h155};
    do @(negedge clk); while (!ack);
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0; burst_mode = 1'b1; addr = '0;
    wait_done();
    // R11: reset in the middle of an access
    go(0, 1, {12'h777, 10'h002});
    repeat (3) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    repeat (3) @(posedge clk);
    go(0, 0, {12'h001, 10'h001}); wait_done();
    repeat (4) @(posedge clk);
    #1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule